// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer

This block is the digital controller of a successive-approximation analog-to-digital converter. One start pulse, with the configuration present in the same cycle, launches a conversion. The block first spends a start-up overhead, counted partly in bus clocks and partly in conversion-clock ticks. It waits out the clock wake-up delay when the conversion clock was not already running. It then holds the input in sample mode for a window of configurable length. After that it runs one successive-approximation trial per tick, from the most significant bit down, and optionally pads each conversion with a high-speed penalty.

The conversion clock reaches the block as a one-cycle enable (`adck_tick`) on the bus clock. The analog side is external: the block drives the sample/hold control and the trial code for the DAC, and reads back a single comparator bit. For hardware averaging, the sample/trial/penalty sequence repeats N times. The codes are summed and scaled by a right shift. The final value is written to `result` in the same cycle that `done` pulses, together with the number of bus clocks the whole request took.

Top module: `adc_seq`

## Requirements
- R1: After reset `busy`, `done`, `sample_hold`, `dac_code`, `result` and `cycle_count` are all 0.
- R2: `sample_hold` is 1 from the cycle after a start is accepted until the sample window ends, and 0 during the trials. `dac_code` is 0 whenever no trial is running, and the first trial drives only the MSB of the selected resolution.
- R3: Trials go from MSB to LSB, one per tick. A bit is kept when `cmp_in` is 1 (input ≥ trial code), so a steady input yields its code clipped to the all-ones value of the resolution. `res_mode` selects 0→8, 1→10, 2→12, 3→16 bits.
- R4: With a tick every cycle, `cycle_count` = 5 + W + S + N × (3 + L + B + H). W is the wake delay, S is 3 or 5, L is the long-sample extension, B is the bit count and H is 0 or 4.
- R5: `hs_mode` = 1 adds exactly 4 ticks to every conversion of a request.
- R6: With `long_smp` = 1, `lsmp_sel` extends the 3-tick sample window by 0→20, 1→12, 2→6, 3→2 ticks. With `long_smp` = 0 there is no extension.
- R7: `slow_start` = 0 gives a start-up adder of 3 ticks and `slow_start` = 1 gives 5 ticks, in both cases after 5 bus clocks.
- R8: When `clk_ready` = 0 at start, a further `WAKE_CYC` bus clocks (default 250) are spent before the start-up ticks. When it is 1, none are spent.
- R9: `avg_sel` selects N as 0→1, 1→4, 2→8, 3→16, and 4 or above→32. The result is the sum of N codes shifted right by log2 N.
- R10: `done` is high for exactly one cycle per completed request, and `result` changes only in that cycle.
- R11: A start while busy abandons the running request without a `done` and restarts it from the beginning with the new configuration.
- R12: The tick-counted phases advance only on `adck_tick`. The bus-counted phases advance on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | bus clock |
| rst_n | input | 1 | active-low asynchronous reset |
| adck_tick | input | 1 | conversion-clock enable |
| start | input | 1 | start or restart request |
| long_smp | input | 1 | long sample window enable |
| lsmp_sel | input | 2 | long sample extension select |
| hs_mode | input | 1 | high-speed mode, adds 4 ticks |
| res_mode | input | 2 | resolution select |
| avg_sel | input | 3 | averaging count select |
| slow_start | input | 1 | 5-tick rather than 3-tick start-up adder |
| clk_ready | input | 1 | conversion clock already running |
| cmp_in | input | 1 | comparator: input ≥ trial code |
| busy | output | 1 | request in progress |
| done | output | 1 | one-cycle completion pulse |
| sample_hold | output | 1 | 1 = sampling input |
| dac_code | output | 16 | trial code for the DAC |
| result | output | 16 | averaged conversion result |
| cycle_count | output | 24 | bus clocks spent on the last request |

## Verification
The assertions take it that `start` is a single-cycle pulse and that `cmp_in` is a function of the present `dac_code`, as a real comparator would give. They also take it that configuration only matters in the cycle of `start`. The bench builds `cmp_in` combinationally from a modelled input voltage and the trial code. It drives each start for one cycle on the falling edge, with the configuration set beside it. For averaging, it moves the modelled input only at the rising edge of `sample_hold`, so each code of a set sees one steady value during its trials.

// File: rtl/adc_seq.sv
module adc_seq #(
  parameter int WAKE_CYC = 250,
  parameter int BUS_ADD  = 5,
  parameter int HS_ADD   = 4,
  parameter int CW       = 16,
  parameter int OUT_W    = 16,
  parameter int CYC_W    = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adck_tick,
  input  logic             start,
  input  logic             long_smp,
  input  logic [1:0]       lsmp_sel,
  input  logic             hs_mode,
  input  logic [1:0]       res_mode,
  input  logic [2:0]       avg_sel,
  input  logic             slow_start,
  input  logic             clk_ready,
  input  logic             cmp_in,
  output logic             busy,
  output logic             done,
  output logic             sample_hold,
  output logic [OUT_W-1:0] dac_code,
  output logic [OUT_W-1:0] result,
  output logic [CYC_W-1:0] cycle_count
);
  localparam int ACC_W = OUT_W + 5;
  localparam int BW    = $clog2(OUT_W);

  typedef enum logic [2:0] {S_IDLE, S_BUS, S_WAKE, S_START, S_SMP, S_SAR, S_HS} st_t;
  st_t st;

  logic [CW-1:0]    cnt;
  logic [CYC_W-1:0] cyc;
  logic [BW-1:0]    bitk;
  logic [OUT_W-1:0] sar;
  logic [ACC_W-1:0] acc;
  logic [5:0]       conv_left;
  logic             c_long, c_hs, c_slow, c_ready;
  logic [1:0]       c_sel, c_mode;
  logic [2:0]       c_shift;

  logic [4:0]       nbits;
  logic [4:0]       smp_len;
  logic [2:0]       shift_in;
  logic [OUT_W-1:0] trial, conv_now;
  logic             sar_last, conv_end;
  logic [ACC_W-1:0] acc_sum;

  always_comb begin
    case (c_mode)
      2'd0: nbits = 5'd8;
      2'd1: nbits = 5'd10;
      2'd2: nbits = 5'd12;
      default: nbits = 5'd16;
    endcase
    if (!c_long) smp_len = 5'd3;
    else case (c_sel)
      2'd0: smp_len = 5'd23;
      2'd1: smp_len = 5'd15;
      2'd2: smp_len = 5'd9;
      default: smp_len = 5'd5;
    endcase
    case (avg_sel)
      3'd0: shift_in = 3'd0;
      3'd1: shift_in = 3'd2;
      3'd2: shift_in = 3'd3;
      3'd3: shift_in = 3'd4;
      default: shift_in = 3'd5;
    endcase
  end

  assign trial    = sar | (OUT_W'(1) << bitk);
  assign conv_now = cmp_in ? trial : sar;
  assign sar_last = (st == S_SAR) && adck_tick && (bitk == '0);
  assign acc_sum  = acc + (sar_last ? ACC_W'(conv_now) : '0);
  assign conv_end = (sar_last && !c_hs) ||
                    ((st == S_HS) && adck_tick && (cnt == CW'(HS_ADD - 1)));

  assign busy        = (st != S_IDLE);
  assign sample_hold = (st == S_BUS) || (st == S_WAKE) || (st == S_START) || (st == S_SMP);
  assign dac_code    = (st == S_SAR) ? trial : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; cyc <= '0; bitk <= '0; sar <= '0; acc <= '0;
      conv_left <= '0; c_long <= 1'b0; c_hs <= 1'b0; c_slow <= 1'b0; c_ready <= 1'b0;
      c_sel <= '0; c_mode <= '0; c_shift <= '0;
      done <= 1'b0; result <= '0; cycle_count <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        st <= S_BUS; cnt <= '0; cyc <= '0; acc <= '0; sar <= '0; bitk <= '0;
        conv_left <= 6'd1 << shift_in; c_shift <= shift_in;
        c_long <= long_smp; c_sel <= lsmp_sel; c_hs <= hs_mode; c_mode <= res_mode;
        c_slow <= slow_start; c_ready <= clk_ready;
      end else begin
        if (busy) cyc <= cyc + 1'b1;
        case (st)
          S_BUS:
            if (cnt == CW'(BUS_ADD - 1)) begin
              cnt <= '0;
              st  <= c_ready ? S_START : S_WAKE;
            end else cnt <= cnt + 1'b1;
          S_WAKE:
            if (cnt == CW'(WAKE_CYC - 1)) begin
              cnt <= '0;
              st  <= S_START;
            end else cnt <= cnt + 1'b1;
          S_START:
            if (adck_tick) begin
              if (cnt == (c_slow ? CW'(4) : CW'(2))) begin
                cnt <= '0;
                st  <= S_SMP;
              end else cnt <= cnt + 1'b1;
            end
          S_SMP:
            if (adck_tick) begin
              if (cnt == CW'(smp_len - 5'd1)) begin
                cnt  <= '0;
                sar  <= '0;
                bitk <= BW'(nbits - 5'd1);
                st   <= S_SAR;
              end else cnt <= cnt + 1'b1;
            end
          S_SAR:
            if (adck_tick) begin
              sar <= conv_now;
              if (bitk == '0) begin
                acc <= acc_sum;
                if (c_hs) begin
                  cnt <= '0;
                  st  <= S_HS;
                end
              end else bitk <= bitk - 1'b1;
            end
          S_HS:
            if (adck_tick && !conv_end) cnt <= cnt + 1'b1;
          default: ;
        endcase
        if (conv_end) begin
          cnt <= '0;
          if (conv_left == 6'd1) begin
            st          <= S_IDLE;
            done        <= 1'b1;
            result      <= OUT_W'(acc_sum >> c_shift);
            cycle_count <= cyc + 1'b1;
          end else begin
            conv_left <= conv_left - 1'b1;
            st        <= S_SMP;
          end
        end
      end
    end
  end
endmodule

module adc_seq_chk #(
  parameter int OUT_W = 16,
  parameter int CYC_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             sample_hold,
  input logic [OUT_W-1:0] dac_code,
  input logic [OUT_W-1:0] result,
  input logic [CYC_W-1:0] cycle_count
);
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_result_only_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> done);
  a_r10_done_leaves_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |-> !busy);
  a_r2_no_trial_while_sampling: assert property (@(posedge clk) disable iff (!rst_n)
    sample_hold |-> (dac_code == '0));
  a_r2_idle_dac_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (dac_code == '0) && !sample_hold);
  a_r11_start_enters_sampling: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy && sample_hold && !done);
  a_r4_min_latency: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (cycle_count >= CYC_W'(19)));
endmodule

bind adc_seq adc_seq_chk #(.OUT_W(OUT_W), .CYC_W(CYC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .sample_hold(sample_hold), .dac_code(dac_code), .result(result),
  .cycle_count(cycle_count));

// File: tb/sim_adc_seq.sv
module sim_adc_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic slow_tick = 1'b0, ph = 1'b0;
  logic start = 1'b0, long_smp = 1'b0, hs_mode = 1'b0, slow_start = 1'b0, clk_ready = 1'b1;
  logic [1:0] lsmp_sel = '0, res_mode = '0;
  logic [2:0] avg_sel = '0;
  logic [15:0] vin = '0;
  logic busy, done, sample_hold;
  logic [15:0] dac_code, result;
  logic [23:0] cycle_count;
  logic adck_tick, cmp_in;
  int checks = 0, errors = 0;
  logic noise_en = 1'b0;
  int nidx = 0;
  int done_seen = 0;

  always #10 clk = ~clk;
  always @(posedge clk) ph <= ~ph;
  assign adck_tick = slow_tick ? ph : 1'b1;
  assign cmp_in = (vin >= dac_code);

  always @(posedge sample_hold) if (noise_en) begin
    case (nidx % 4)
      0: vin <= 16'd100;
      1: vin <= 16'd103;
      2: vin <= 16'd98;
      default: vin <= 16'd107;
    endcase
    nidx <= nidx + 1;
  end
  always @(posedge clk) if (done) done_seen <= done_seen + 1;

  adc_seq u0 (.clk(clk), .rst_n(rst_n), .adck_tick(adck_tick), .start(start),
    .long_smp(long_smp), .lsmp_sel(lsmp_sel), .hs_mode(hs_mode), .res_mode(res_mode),
    .avg_sel(avg_sel), .slow_start(slow_start), .clk_ready(clk_ready), .cmp_in(cmp_in),
    .busy(busy), .done(done), .sample_hold(sample_hold), .dac_code(dac_code),
    .result(result), .cycle_count(cycle_count));

  typedef struct packed {
    logic [1:0] mode; logic [2:0] avg; logic hs; logic lng; logic [1:0] sel;
    logic sl; logic rdy; logic [15:0] v;
  } vec_t;
  localparam int NV = 10;
  localparam vec_t VT [NV] = '{
    '{2'd0, 3'd0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 16'h005A},
    '{2'd1, 3'd0, 1'b1, 1'b1, 2'd0, 1'b1, 1'b1, 16'd700},
    '{2'd2, 3'd0, 1'b0, 1'b1, 2'd1, 1'b0, 1'b1, 16'd4000},
    '{2'd3, 3'd0, 1'b1, 1'b1, 2'd2, 1'b0, 1'b1, 16'hBEEF},
    '{2'd0, 3'd0, 1'b0, 1'b1, 2'd3, 1'b1, 1'b1, 16'd300},
    '{2'd2, 3'd0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 16'd1234},
    '{2'd1, 3'd1, 1'b1, 1'b0, 2'd0, 1'b0, 1'b1, 16'd513},
    '{2'd0, 3'd4, 1'b0, 1'b1, 2'd0, 1'b0, 1'b1, 16'd77},
    '{2'd3, 3'd3, 1'b0, 1'b0, 2'd1, 1'b1, 1'b0, 16'd0},
    '{2'd3, 3'd2, 1'b1, 1'b1, 2'd3, 1'b1, 1'b1, 16'hFFFF}
  };

  function automatic int nb_of(input logic [1:0] m);
    return (m == 0) ? 8 : (m == 1) ? 10 : (m == 2) ? 12 : 16;
  endfunction
  function automatic int sh_of(input logic [2:0] a);
    return (a == 0) ? 0 : (a == 1) ? 2 : (a == 2) ? 3 : (a == 3) ? 4 : 5;
  endfunction
  function automatic int lsa_of(input logic l, input logic [1:0] s);
    if (!l) return 0;
    return (s == 0) ? 20 : (s == 1) ? 12 : (s == 2) ? 6 : 2;
  endfunction
  function automatic int exp_cnt(input vec_t t);
    return 5 + (t.rdy ? 0 : 250) + (t.sl ? 5 : 3) +
      (1 << sh_of(t.avg)) * (3 + lsa_of(t.lng, t.sel) + nb_of(t.mode) + (t.hs ? 4 : 0));
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic apply(input vec_t t);
    res_mode = t.mode; avg_sel = t.avg; hs_mode = t.hs; long_smp = t.lng;
    lsmp_sel = t.sel; slow_start = t.sl; clk_ready = t.rdy;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    ok = 0;
    for (int i = 0; i < 20000; i++) begin
      if (done) begin ok = 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic run(input vec_t t, output int cnt, output int res);
    bit ok;
    apply(t);
    if (!noise_en) vin = t.v;
    pulse_start();
    wait_done(ok);
    if (!ok) begin errors++; $display("FAIL R10 no done actual=0 expected=1"); end
    cnt = int'(cycle_count); res = int'(result);
    @(negedge clk);
  endtask

  initial begin
    #3000000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int c, r, c0, c1, d0;
    vec_t t;
    bit ok;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0); chk("R1 done", done, 0); chk("R1 sample_hold", sample_hold, 0);
    chk("R1 dac_code", dac_code, 0); chk("R1 result", result, 0); chk("R1 cycle_count", cycle_count, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      run(VT[i], c, r);
      chk($sformatf("R3 R9 result row %0d", i), r,
          (VT[i].v > ((1 << nb_of(VT[i].mode)) - 1)) ? ((1 << nb_of(VT[i].mode)) - 1) : VT[i].v);
      chk($sformatf("R4 R6 R7 R8 count row %0d", i), c, exp_cnt(VT[i]));
    end

    // R2 sample window and first trial
    t = VT[2]; apply(t); vin = t.v;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R2 sampling after start", sample_hold, 1);
    chk("R2 dac quiet while sampling", dac_code, 0);
    for (int i = 0; i < 100 && sample_hold; i++) @(negedge clk);
    chk("R2 first trial MSB", dac_code, 16'h0800);
    wait_done(ok); @(negedge clk);

    // R5 high-speed adder per conversion, with averaging 4
    t = VT[6]; t.hs = 1'b0; run(t, c0, r);
    t.hs = 1'b1; run(t, c1, r);
    chk("R5 hs adds 4 per conversion", c1 - c0, 16);

    // R9 averaging of varying input
    noise_en = 1'b1; nidx = 0;
    t = VT[0]; t.avg = 3'd1; run(t, c, r);
    chk("R9 average of four samples", r, 102);
    noise_en = 1'b0;

    // R10 and R11 abort and restart
    d0 = done_seen;
    t = VT[3]; apply(t); vin = t.v;
    pulse_start();
    repeat (20) @(negedge clk);
    t = VT[1]; run(t, c, r);
    chk("R11 restart count", c, exp_cnt(VT[1]));
    chk("R11 restart result", r, 700);
    chk("R10 single done per request", done_seen - d0, 1);

    // R12 slow conversion clock
    slow_tick = 1'b1;
    t = VT[0]; run(t, c, r);
    checks++;
    if (c < 5 + 2 * 14 - 1 || c > 5 + 2 * 14 + 1) begin
      errors++;
      $display("FAIL R12 slow tick count actual=%0d expected=%0d", c, 5 + 2 * 14);
    end
    chk("R12 slow tick result", r, 90);
    slow_tick = 1'b0;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule